// File: doc/BRIEF.md
# 16-Bit Timer/Counter with Capture and Reload

This block is a 16-bit up-counter held as two byte-wide lanes. It advances either once per machine-cycle tick (timer use) or once per falling edge on an external count pin (event-counter use). Both external pins pass through a two-stage synchroniser. A falling edge is recognised when the sampled level goes from 1 to 0 between consecutive clocks.

A single 16-bit capture/reload register pair serves two modes. In capture mode an external trigger edge copies the live count into the pair. In reload mode the count is reloaded from the pair when it overflows, and also on a trigger edge if the external enable is set. When either baud-clock select is active, overflow reloads the count and drives a one-cycle pulse for a serial rate generator, and the overflow flag is held off. The external flag records accepted trigger edges. Software writes the count and the pair one byte at a time, and clears the flags through dedicated inputs.

Top module: `ctr16_capreload`

## Requirements
- R1: After reset, count and capreg read 0, and ovf_flag, ext_flag and baud_pulse are 0.
- R2: With run=1 and ev_mode=0, count rises by one on each clock where tick_en=1. It holds when tick_en=0 or run=0.
- R3: With run=1 and ev_mode=1, tick_en is ignored and count rises by one per falling edge of cnt_pin. A pin that falls before clock edge k gives the new count after edge k+2, so the first two edges show no change. A rising edge does not count.
- R4: In capture mode (cap_mode=1) with no baud select, an increment from 16'hFFFF gives 16'h0000 and sets ovf_flag on the same edge. baud_pulse is 1 for the following cycle.
- R5: In reload mode (cap_mode=0), an increment from 16'hFFFF loads count from capreg and sets ovf_flag.
- R6: In capture mode with ext_en=1, a falling edge of trig_pin (synchronised as in R3) copies count into capreg and sets ext_flag. With ext_en=0 the edge changes neither capreg nor ext_flag.
- R7: In reload mode with ext_en=1, a falling edge of trig_pin loads count from capreg and sets ext_flag. The reload wins over an increment on the same edge.
- R8: While rx_baud or tx_baud is 1, overflow never sets ovf_flag. Overflow still reloads count from capreg and pulses baud_pulse, whatever cap_mode is. A trigger edge with ext_en=1 only sets ext_flag, leaving count and capreg unchanged.
- R9: When wr_en=1, wr_data is written into the byte chosen by wr_sel: 0 = count low, 1 = count high, 2 = capreg low, 3 = capreg high. The write takes precedence over any count or capture action on that byte's register in the same cycle.
- R10: ovf_clr and ext_clr clear their flag on the next edge. A flag set event on the same edge wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Machine-cycle tick for timer use |
| run | input | 1 | Count enable |
| ev_mode | input | 1 | 1 = count cnt_pin edges, 0 = count ticks |
| ext_en | input | 1 | Enables trigger-pin action |
| cap_mode | input | 1 | 1 = capture mode, 0 = reload mode |
| rx_baud | input | 1 | Receive baud-clock select |
| tx_baud | input | 1 | Transmit baud-clock select |
| cnt_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous external trigger input |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte select for writes |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Clear overflow flag |
| ext_clr | input | 1 | Clear external flag |
| count | output | 16 | Current count |
| capreg | output | 16 | Capture/reload register pair |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag |
| baud_pulse | output | 1 | One-cycle overflow pulse for baud generation |

## Verification
The following are checked on every cycle:
- count stays put when nothing can move it.
- A capture stores the prior count, and a trigger reload loads the pair.
- A capture-mode wrap lands on zero.
- ovf_flag cannot rise while a baud select is active, and stays set until cleared.
- ext_flag only rises after an enabled trigger edge.

Only the bench scenarios show the two-cycle synchroniser latency, the ignoring of rising edges and of tick_en in event use, the byte-lane write encoding and its precedence, and the set-over-clear rule.

// File: rtl/ctr16_pkg.sv
package ctr16_pkg;
  localparam int unsigned LANES = 2;

  typedef struct packed {
    logic run;
    logic ev_mode;
    logic ext_en;
    logic cap_mode;
    logic baud_any;
  } ctl_t;
endpackage

// File: rtl/ctr16_sync.sv
module ctr16_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  logic [STAGES-1:0][N-1:0] stg_q, stg_nx;
  logic [N-1:0]             prev_q, prev_nx;

  always_comb begin
    stg_nx  = {stg_q[STAGES-2:0], pin};
    prev_nx = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '1;
      prev_q <= '1;
    end else begin
      stg_q  <= stg_nx;
      prev_q <= prev_nx;
    end
  end

  assign fall = prev_q & ~stg_q[STAGES-1];
endmodule

// File: rtl/ctr16_count.sv
module ctr16_count
  import ctr16_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic              tick_en,
  input  logic              ev_fall,
  input  logic              trig_fall,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capreg,
  output logic              wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, cap_q, cap_nx;
  logic inc, ext_act, trig_reload, trig_capture, reload_on_wrap;
  logic wr_cnt, wr_cap;

  always_comb begin
    inc            = ctl.run & (ctl.ev_mode ? ev_fall : tick_en);
    wrap           = inc & (cnt_q == '1);
    reload_on_wrap = ~ctl.cap_mode | ctl.baud_any;
    ext_act        = ctl.ext_en & trig_fall;
    trig_reload    = ext_act & ~ctl.cap_mode & ~ctl.baud_any;
    trig_capture   = ext_act & ctl.cap_mode & ~ctl.baud_any;
    wr_cnt         = wr_en & ~wr_sel[1];
    wr_cap         = wr_en & wr_sel[1];
  end

  always_comb begin
    cnt_nx = cnt_q;
    if (inc) begin
      if (wrap) cnt_nx = reload_on_wrap ? cap_q : '0;
      else      cnt_nx = cnt_q + 1'b1;
    end
    if (trig_reload) cnt_nx = cap_q;
    if (wr_cnt) cnt_nx[wr_sel[0]*BYTE_W +: BYTE_W] = wr_data;
  end

  always_comb begin
    cap_nx = cap_q;
    if (trig_capture) cap_nx = cnt_q;
    if (wr_cap) cap_nx[wr_sel[0]*BYTE_W +: BYTE_W] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      cap_q <= cap_nx;
    end
  end

  assign count  = cnt_q;
  assign capreg = cap_q;

  // R2: the count only moves for an increment, a trigger or a write
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc | ext_act | wr_en) |=> $stable(cnt_q));
  // R6: a capture stores the count seen on the capturing edge
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_capture && !wr_cap) |=> cap_q == $past(cnt_q));
  // R7: a trigger reload loads the pair
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_reload && !wr_en) |=> cnt_q == $past(cap_q));
  // R4: capture-mode wrap lands on zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && ctl.cap_mode && !ctl.baud_any && !wr_en) |=> cnt_q == '0);
endmodule

// File: rtl/ctr16_flags.sv
module ctr16_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic baud_any,
  input  logic ext_act,
  input  logic ovf_clr,
  input  logic ext_clr,
  output logic ovf_flag,
  output logic ext_flag,
  output logic baud_pulse
);
  logic ovf_q, ovf_nx, ext_q, ext_nx, pls_q, pls_nx;

  always_comb begin
    ovf_nx = (wrap & ~baud_any) | (ovf_q & ~ovf_clr);
    ext_nx = ext_act | (ext_q & ~ext_clr);
    pls_nx = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      ext_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      ovf_q <= ovf_nx;
      ext_q <= ext_nx;
      pls_q <= pls_nx;
    end
  end

  assign ovf_flag   = ovf_q;
  assign ext_flag   = ext_q;
  assign baud_pulse = pls_q;

  // R8: a baud select keeps a clear overflow flag clear
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_any && !ovf_q) |=> !ovf_q);
  // R10: the overflow flag stays set until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/ctr16_capreload.sv
module ctr16_capreload
  import ctr16_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run,
  input  logic              ev_mode,
  input  logic              ext_en,
  input  logic              cap_mode,
  input  logic              rx_baud,
  input  logic              tx_baud,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_clr,
  input  logic              ext_clr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capreg,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              baud_pulse
);
  logic [1:0] rst_q;
  logic       rst_i_n;
  ctl_t       ctl;
  logic [1:0] fall;
  logic       wrap, ext_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  always_comb begin
    ctl.run      = run;
    ctl.ev_mode  = ev_mode;
    ctl.ext_en   = ext_en;
    ctl.cap_mode = cap_mode;
    ctl.baud_any = rx_baud | tx_baud;
    ext_act      = ext_en & fall[1];
  end

  ctr16_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .pin({trig_pin, cnt_pin}), .fall(fall)
  );

  ctr16_count #(.BYTE_W(BYTE_W)) u_count (
    .clk(clk), .rst_n(rst_i_n), .ctl(ctl), .tick_en(tick_en),
    .ev_fall(fall[0]), .trig_fall(fall[1]), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .count(count),
    .capreg(capreg), .wrap(wrap)
  );

  ctr16_flags u_flags (
    .clk(clk), .rst_n(rst_i_n), .wrap(wrap), .baud_any(ctl.baud_any),
    .ext_act(ext_act), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_pulse(baud_pulse)
  );

  // R6: the external flag rises only after an enabled trigger edge
  p_ext_cause_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ext_flag) |-> $past(ext_en && fall[1]));
endmodule

// File: tb/ctr16_capreload_tb.sv
module ctr16_capreload_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, run, ev_mode, ext_en, cap_mode, rx_baud, tx_baud;
  logic cnt_pin, trig_pin, wr_en, ovf_clr, ext_clr;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [15:0] count, capreg;
  logic ovf_flag, ext_flag, baud_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          which;
    logic [15:0] val;
    string       tag;
  } item_t;
  item_t q[$];
  event sample_ev;

  always #5 clk = ~clk;

  ctr16_capreload u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .ev_mode(ev_mode),
    .ext_en(ext_en), .cap_mode(cap_mode), .rx_baud(rx_baud), .tx_baud(tx_baud),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .ext_clr(ext_clr), .count(count),
    .capreg(capreg), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .baud_pulse(baud_pulse)
  );

  function automatic logic [15:0] pick(int w);
    case (w)
      0: return count;
      1: return capreg;
      2: return {15'd0, ovf_flag};
      3: return {15'd0, ext_flag};
      default: return {15'd0, baud_pulse};
    endcase
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = pick(it.which);
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
        end
      end
    end
  end

  task automatic expect_v(int w, logic [15:0] v, string tag);
    item_t it;
    it.which = w; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check_now();
    -> sample_ev;
    #1;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cnt(logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before all requirements were checked");
      summary();
      $finish;
    end
  end

  initial begin
    tick_en = 0; run = 0; ev_mode = 0; ext_en = 0; cap_mode = 1;
    rx_baud = 0; tx_baud = 0; cnt_pin = 1; trig_pin = 1;
    wr_en = 0; wr_sel = 0; wr_data = 0; ovf_clr = 0; ext_clr = 0;
    rst_n = 0;
    cyc(3); rst_n = 1; cyc(3);

    // R1 reset state
    expect_v(0, 16'h0, "R1 count"); expect_v(1, 16'h0, "R1 capreg");
    expect_v(2, 16'h0, "R1 ovf");   expect_v(3, 16'h0, "R1 ext");
    expect_v(4, 16'h0, "R1 pulse"); check_now();

    // R9 byte writes
    wr(2'd0, 8'h34); wr(2'd1, 8'h12); wr(2'd2, 8'hCD); wr(2'd3, 8'hAB);
    expect_v(0, 16'h1234, "R9 count bytes"); expect_v(1, 16'hABCD, "R9 capreg bytes");
    check_now();

    // R2 timer use
    run = 1; tick_en = 1; cyc(5);
    expect_v(0, 16'h1239, "R2 five ticks"); check_now();
    tick_en = 0; cyc(3);
    expect_v(0, 16'h1239, "R2 no tick holds"); check_now();
    tick_en = 1; run = 0; cyc(4);
    expect_v(0, 16'h1239, "R2 run low holds"); check_now();
    run = 1;
    for (int i = 0; i < 6; i++) begin tick_en = i[0]; @(negedge clk); end
    tick_en = 0; run = 0;
    expect_v(0, 16'h123C, "R2 gated ticks"); check_now();

    // R4 capture-mode wrap
    set_cnt(16'hFFFD);
    run = 1; tick_en = 1; cyc(3); run = 0;
    expect_v(0, 16'h0000, "R4 wrap to zero"); expect_v(2, 16'h1, "R4 ovf set");
    expect_v(4, 16'h1, "R4 pulse"); check_now();
    cyc(1);
    expect_v(4, 16'h0, "R4 pulse one cycle"); check_now();
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    expect_v(2, 16'h0, "R10 ovf clear"); check_now();

    // R5 reload-mode wrap
    cap_mode = 0; set_cnt(16'hFFFE);
    run = 1; cyc(2); run = 0;
    expect_v(0, 16'hABCD, "R5 reload on wrap"); expect_v(2, 16'h1, "R5 ovf set");
    check_now();
    ovf_clr = 1; cyc(1); ovf_clr = 0;

    // R8 baud selects
    cap_mode = 1; rx_baud = 1; set_cnt(16'hFFFF);
    run = 1; cyc(1); run = 0;
    expect_v(0, 16'hABCD, "R8 rx reload"); expect_v(2, 16'h0, "R8 rx no ovf");
    expect_v(4, 16'h1, "R8 rx pulse"); check_now();
    rx_baud = 0; tx_baud = 1; set_cnt(16'hFFFF);
    run = 1; cyc(1); run = 0;
    expect_v(0, 16'hABCD, "R8 tx reload"); expect_v(2, 16'h0, "R8 tx no ovf");
    check_now();
    ext_en = 1; set_cnt(16'h2211);
    trig_pin = 0; cyc(3);
    expect_v(3, 16'h1, "R8 trig sets ext"); expect_v(0, 16'h2211, "R8 trig no reload");
    expect_v(1, 16'hABCD, "R8 trig no capture"); check_now();
    trig_pin = 1; cyc(3);
    ext_clr = 1; cyc(1); ext_clr = 0; tx_baud = 0;
    expect_v(3, 16'h0, "R10 ext clear"); check_now();

    // R6 capture on trigger
    set_cnt(16'h0777);
    trig_pin = 0; cyc(2);
    expect_v(1, 16'hABCD, "R6 not yet after two edges"); check_now();
    cyc(1);
    expect_v(1, 16'h0777, "R6 captured"); expect_v(3, 16'h1, "R6 ext set");
    expect_v(0, 16'h0777, "R6 count kept"); check_now();
    trig_pin = 1; cyc(3);
    ext_clr = 1; cyc(1); ext_clr = 0;
    ext_en = 0; set_cnt(16'h0555);
    trig_pin = 0; cyc(3);
    expect_v(1, 16'h0777, "R6 disabled no capture"); expect_v(3, 16'h0, "R6 disabled no flag");
    check_now();
    trig_pin = 1; cyc(3);

    // R7 trigger reload wins over increment
    cap_mode = 0; ext_en = 1; set_cnt(16'h0100);
    tick_en = 1; run = 1; trig_pin = 0; cyc(3); run = 0;
    expect_v(0, 16'h0777, "R7 trigger reload"); expect_v(3, 16'h1, "R7 ext set");
    check_now();
    trig_pin = 1; cyc(3);
    ext_clr = 1; cyc(1); ext_clr = 0; ext_en = 0;

    // R3 event counting
    set_cnt(16'h0010);
    ev_mode = 1; run = 1; tick_en = 1; cyc(4);
    expect_v(0, 16'h0010, "R3 ticks ignored"); check_now();
    cnt_pin = 0; cyc(2);
    expect_v(0, 16'h0010, "R3 sync latency"); check_now();
    cyc(1);
    expect_v(0, 16'h0011, "R3 first edge"); check_now();
    cnt_pin = 1; cyc(3);
    expect_v(0, 16'h0011, "R3 rise not counted"); check_now();
    cnt_pin = 0; cyc(3);
    expect_v(0, 16'h0012, "R3 second edge"); check_now();
    cnt_pin = 1; cyc(3); run = 0; ev_mode = 0;

    // R9 write precedence over increment
    run = 1; tick_en = 1;
    wr(2'd0, 8'h55);
    expect_v(0, 16'h0055, "R9 write wins"); check_now();
    cyc(1);
    expect_v(0, 16'h0056, "R9 counts after write"); check_now();
    run = 0;

    // R10 set wins over clear
    cap_mode = 1; set_cnt(16'hFFFF);
    ovf_clr = 1; run = 1; cyc(1); run = 0;
    expect_v(2, 16'h1, "R10 set wins"); check_now();
    cyc(1); ovf_clr = 0;
    expect_v(2, 16'h0, "R10 clear after"); check_now();

    done = 1;
    summary();
    $finish;
  end
endmodule